// File: doc/BRIEF.md
# Single-Master Bus Address Decoder and Response Router

This block is the interconnect between one bus master and a small set of slaves on a pipelined, 32-bit single-master system bus. Each cycle it looks at the top bits of the address and raises the select line of the slave that owns that region. If no slave owns the address, it selects an internal fallback responder. On the return path it picks the read data, ready and response of one slave and hands them to the master. The chosen ready also goes back to every slave as the shared bus-ready.

Transfers overlap: the address of one transfer is on the bus while the previous transfer is in its data phase. For this reason the return-path select is a register. It captures the decoded owner only on a clock edge where the shared ready is high, so the response always comes from the slave whose data phase is in progress. The fallback responder completes idle and busy cycles at once with an OKAY response. It answers a real access to an unmapped address with the standard two-cycle error.

Top module: `ahbl_fabric`

## Requirements
- R1: `slv_sel[i]` is high, combinationally, exactly when `m_addr[31:28]` equals i, for i from 0 to 3. For any other value of those bits, every `slv_sel` line is low and the fallback responder is selected instead.
- R2: When `bus_ready` is high at a rising edge, the address phase on the bus at that edge completes. In the following cycle, `bus_rdata`, `bus_ready` and `bus_resp` equal the read data, ready and response of the slave selected during that address phase.
- R3: While `bus_ready` is low, routing does not change. The outputs keep following the slave that owns the stalled data phase, even when `m_addr` moves to a region owned by another slave.
- R4: An access with `m_trans` of 2'b10 (first beat) or 2'b11 (following beat) to an unmapped address gets a two-cycle response. In the first data-phase cycle, `bus_ready` is 0 and `bus_resp` is 1. In the second, `bus_ready` is 1 and `bus_resp` is 1.
- R5: A cycle with `m_trans` of 2'b00 (idle) or 2'b01 (busy) to an unmapped address completes in its first data-phase cycle with `bus_ready` = 1 and `bus_resp` = 0 (OKAY).
- R6: During and right after synchronous reset (`rst_n` low), routing points at the fallback responder: `bus_ready` = 1, `bus_resp` = 0 and `bus_rdata` = 0, whatever the slaves drive.
- R7: Whenever the fallback responder owns the data phase, `bus_rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| m_addr | input | 32 | Master address |
| m_trans | input | 2 | Master transfer type: 00 idle, 01 busy, 10 first beat, 11 following beat |
| slv_sel | output | 4 | Per-slave select, decoded from `m_addr[31:28]` |
| slv_rdata | input | 128 | Read data of all slaves; slave i uses bits [32*i+31:32*i] |
| slv_readyout | input | 4 | Per-slave transfer-done indication |
| slv_resp | input | 4 | Per-slave response, 1 = error |
| bus_rdata | output | 32 | Read data routed to the master |
| bus_ready | output | 1 | Shared ready to the master and to all slaves |
| bus_resp | output | 1 | Response routed to the master, 1 = error |

## Verification
The assertions assume that the master follows the pipelined protocol. The address and transfer type are valid at every edge where `bus_ready` is high, and `m_trans` is never unknown after reset. The slaves must drive known ready, response and data values whenever they own a data phase. The bench changes master and slave inputs only on falling edges and keeps every slave output at a defined level. It changes the address during a stall only to show that routing holds, and it lets slave ready drop only while that slave owns the data phase.

// File: rtl/ahbl_fabric_pkg.sv
// Package: shared transfer-type codes and fallback-responder state.
// Assumes: a 2-bit transfer type whose upper bit marks a real access.
package ahbl_fabric_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_FIRST  = 2'b10,
        TR_FOLLOW = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        FB_OKAY = 2'b00,
        FB_ERR1 = 2'b01,
        FB_ERR2 = 2'b10
    } fb_state_e;

    // True when the transfer type demands a data transfer.
    function automatic logic is_access(input logic [1:0] kind);
        return kind[1];
    endfunction

endpackage

// File: rtl/region_decoder.sv
// Region decoder: turns the top address bits into one select per slave,
// plus a fallback select when no slave owns the address.
// Assumes: slave i owns the region whose index field equals i, and
// N_SLV does not exceed the number of codes of that field.
module region_decoder #(
    parameter int ADDR_W = 32,
    parameter int N_SLV  = 4,
    parameter int RG_MSB = 31,
    parameter int RG_LSB = 28
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [N_SLV-1:0]  sel_o,
    output logic              fb_sel_o
);
    localparam int RG_W = RG_MSB - RG_LSB + 1;

    logic [RG_W-1:0] region;
    assign region = addr_i[RG_MSB:RG_LSB];

    // One comparator per slave region.
    for (genvar i = 0; i < N_SLV; i++) begin : g_cmp
        assign sel_o[i] = (region == RG_W'(i));
    end

    // Fallback owns every address that no slave claims.
    assign fb_sel_o = ~|sel_o;

endmodule

// File: rtl/fallback_responder.sv
// Fallback responder: answers unmapped addresses. Idle and busy cycles
// finish at once with OKAY; a real access gets a two-cycle error.
// Assumes: ready_i is the shared bus ready, so a new transfer is taken
// only on an edge where the previous one completes.
module fallback_responder
    import ahbl_fabric_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_i,
    input  logic [1:0] trans_i,
    input  logic       ready_i,
    output logic       ready_o,
    output logic       resp_o
);
    fb_state_e state_q;
    logic      take;

    assign take = sel_i && ready_i && is_access(trans_i);

    // Sequence the error response, then accept a new access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FB_OKAY;
        end else if (state_q == FB_ERR1) begin
            state_q <= FB_ERR2;
        end else if (take) begin
            state_q <= FB_ERR1;
        end else begin
            state_q <= FB_OKAY;
        end
    end

    // Outputs depend on the state alone.
    always_comb begin
        ready_o = (state_q != FB_ERR1);
        resp_o  = (state_q != FB_OKAY);
    end

    // R4: an access taken here starts the error with ready low.
    assert_err_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!ready_o && resp_o));

    // R4: a low-ready error cycle is always followed by the closing cycle.
    assert_err_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> (ready_o && resp_o));

endmodule

// File: rtl/response_router.sv
// Response router: picks the data, ready and response of the data-phase
// owner. Index N_SLV stands for the fallback responder.
// Assumes: the index never exceeds N_SLV.
module response_router #(
    parameter int N_SLV  = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [N_SLV*DATA_W-1:0] rdata_i,
    input  logic [N_SLV-1:0]        ready_i,
    input  logic [N_SLV-1:0]        resp_i,
    input  logic                    fb_ready_i,
    input  logic                    fb_resp_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic                    ready_o,
    output logic                    resp_o
);
    // Default to the fallback, override with the indexed slave.
    always_comb begin
        rdata_o = '0;
        ready_o = fb_ready_i;
        resp_o  = fb_resp_i;
        for (int i = 0; i < N_SLV; i++) begin
            if (idx_i == IDX_W'(i)) begin
                rdata_o = rdata_i[i*DATA_W +: DATA_W];
                ready_o = ready_i[i];
                resp_o  = resp_i[i];
            end
        end
    end

endmodule

// File: rtl/ahbl_fabric.sv
// Top: address decode towards the slaves and response routing back to
// the master. The routing index is the address-phase decode registered
// on every edge where the shared ready is high.
// Assumes: a single master that follows the pipelined transfer protocol.
module ahbl_fabric
    import ahbl_fabric_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int N_SLV  = 4,
    parameter int RG_MSB = 31,
    parameter int RG_LSB = 28
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       m_addr,
    input  logic [1:0]              m_trans,
    output logic [N_SLV-1:0]        slv_sel,
    input  logic [N_SLV*DATA_W-1:0] slv_rdata,
    input  logic [N_SLV-1:0]        slv_readyout,
    input  logic [N_SLV-1:0]        slv_resp,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_ready,
    output logic                    bus_resp
);
    localparam int IDX_W   = $clog2(N_SLV + 1);
    localparam int IDX_DEF = N_SLV;

    logic             fb_sel;
    logic             fb_ready;
    logic             fb_resp;
    logic [IDX_W-1:0] idx_d;
    logic [IDX_W-1:0] idx_q;

    region_decoder #(
        .ADDR_W(ADDR_W), .N_SLV(N_SLV), .RG_MSB(RG_MSB), .RG_LSB(RG_LSB)
    ) u_dec (
        .addr_i   (m_addr),
        .sel_o    (slv_sel),
        .fb_sel_o (fb_sel)
    );

    fallback_responder u_fb (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (fb_sel),
        .trans_i (m_trans),
        .ready_i (bus_ready),
        .ready_o (fb_ready),
        .resp_o  (fb_resp)
    );

    // Encode the one-hot decode into a routing index.
    always_comb begin
        idx_d = IDX_W'(IDX_DEF);
        for (int i = 0; i < N_SLV; i++) begin
            if (slv_sel[i]) idx_d = IDX_W'(i);
        end
    end

    // Advance routing only when the previous transfer completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= IDX_W'(IDX_DEF);
        end else if (bus_ready) begin
            idx_q <= idx_d;
        end
    end

    response_router #(
        .N_SLV(N_SLV), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_mux (
        .idx_i      (idx_q),
        .rdata_i    (slv_rdata),
        .ready_i    (slv_readyout),
        .resp_i     (slv_resp),
        .fb_ready_i (fb_ready),
        .fb_resp_i  (fb_resp),
        .rdata_o    (bus_rdata),
        .ready_o    (bus_ready),
        .resp_o     (bus_resp)
    );

    // R1: exactly one owner, counting the fallback.
    assert_one_owner_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({slv_sel, fb_sel}) == 1);

    // R2: a completed address phase hands its slave the next data phase.
    for (genvar i = 0; i < N_SLV; i++) begin : g_route_chk
        assert_route_slave_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_ready && slv_sel[i]) |=>
            (bus_rdata == slv_rdata[i*DATA_W +: DATA_W] &&
             bus_ready == slv_readyout[i] && bus_resp == slv_resp[i]));
    end

    // R3: a stall freezes the routing.
    assert_hold_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |=> $stable(idx_q));

    // R5: idle or busy to an unmapped address completes with OKAY.
    assert_fb_idle_okay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_sel && bus_ready && !is_access(m_trans)) |=> (bus_ready && !bus_resp));

    // R7: fallback data phase returns zero data.
    assert_fb_zero_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == IDX_W'(IDX_DEF)) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_ahbl_fabric.sv
module sim_ahbl_fabric;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  trans;
        logic [3:0]  sel;
        logic [31:0] data;
        logic        resp;
    } vec_t;

    // Slave i returns 32'hC0DE_0000 + i; slave 3 answers with error.
    localparam vec_t VEC [8] = '{
        '{32'h0000_0010, 2'b10, 4'b0001, 32'hC0DE_0000, 1'b0},
        '{32'h1234_5678, 2'b10, 4'b0010, 32'hC0DE_0001, 1'b0},
        '{32'h2FFF_FFFC, 2'b11, 4'b0100, 32'hC0DE_0002, 1'b0},
        '{32'h3000_0000, 2'b10, 4'b1000, 32'hC0DE_0003, 1'b1},
        '{32'h4000_0000, 2'b00, 4'b0000, 32'h0000_0000, 1'b0},
        '{32'hF000_0000, 2'b01, 4'b0000, 32'h0000_0000, 1'b0},
        '{32'h1000_0004, 2'b00, 4'b0010, 32'hC0DE_0001, 1'b0},
        '{32'h0FFF_FFFF, 2'b10, 4'b0001, 32'hC0DE_0000, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic [31:0]      m_addr;
    logic [1:0]       m_trans;
    logic [NS-1:0]    slv_sel;
    logic [NS*32-1:0] slv_rdata;
    logic [NS-1:0]    slv_readyout;
    logic [NS-1:0]    slv_resp;
    logic [31:0]      bus_rdata;
    logic             bus_ready;
    logic             bus_resp;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ahbl_fabric u0 (
        .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_trans(m_trans),
        .slv_sel(slv_sel), .slv_rdata(slv_rdata), .slv_readyout(slv_readyout),
        .slv_resp(slv_resp), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .bus_resp(bus_resp)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_out(input string req, input logic [31:0] d, input logic r, input logic e);
        check({req, " rdata"}, bus_rdata, d);
        check({req, " ready"}, {31'd0, bus_ready}, {31'd0, r});
        check({req, " resp"},  {31'd0, bus_resp},  {31'd0, e});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        // R6: slaves drive hostile values through reset.
        rst_n        = 1'b0;
        m_addr       = 32'h8000_0000;
        m_trans      = 2'b00;
        slv_readyout = '0;
        slv_resp     = '1;
        slv_rdata    = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out("R6 in reset", 32'h0, 1'b1, 1'b0);

        for (int i = 0; i < NS; i++) slv_rdata[i*32 +: 32] = 32'hC0DE_0000 + 32'(i);
        slv_readyout = '1;
        slv_resp     = 4'b1000;
        rst_n        = 1'b1;
        #1;
        check_out("R6 after release", 32'h0, 1'b1, 1'b0);

        // Table: back-to-back pipelined transfers, all slaves ready.
        for (int k = 0; k < 8; k++) begin
            m_addr  = VEC[k].addr;
            m_trans = VEC[k].trans;
            #1;
            check("R1 decode", {28'd0, slv_sel}, {28'd0, VEC[k].sel});
            @(posedge clk);
            @(negedge clk);
            check_out("R2 R5 R7 table data phase", VEC[k].data, 1'b1, VEC[k].resp);
        end

        // R4: first-beat access to an unmapped region.
        m_addr  = 32'h8000_0000;
        m_trans = 2'b10;
        #1;
        check("R1 unmapped", {28'd0, slv_sel}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        check_out("R4 err cycle 1", 32'h0, 1'b0, 1'b1);
        m_addr  = 32'h1000_0000;
        m_trans = 2'b10;
        @(posedge clk);
        @(negedge clk);
        check_out("R4 err cycle 2", 32'h0, 1'b1, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check_out("R2 after error", 32'hC0DE_0001, 1'b1, 1'b0);

        // R3: wait state on slave 2 while the address moves on.
        m_addr  = 32'h2000_0000;
        m_trans = 2'b10;
        @(posedge clk);
        @(negedge clk);
        slv_readyout[2] = 1'b0;
        m_addr  = 32'h3000_0000;
        m_trans = 2'b10;
        #1;
        check_out("R2 stall mirrors ready", 32'hC0DE_0002, 1'b0, 1'b0);
        check("R1 decode during stall", {28'd0, slv_sel}, 32'h8);
        @(posedge clk);
        @(negedge clk);
        check_out("R3 held on stall", 32'hC0DE_0002, 1'b0, 1'b0);
        slv_readyout[2] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_out("R2 slave 3 after stall", 32'hC0DE_0003, 1'b1, 1'b1);

        // R5: idle to unmapped, then following-beat error (R4).
        m_addr  = 32'h5000_0000;
        m_trans = 2'b00;
        @(posedge clk);
        @(negedge clk);
        check_out("R5 idle unmapped", 32'h0, 1'b1, 1'b0);
        m_addr  = 32'hA000_0000;
        m_trans = 2'b11;
        @(posedge clk);
        @(negedge clk);
        m_trans = 2'b00;
        check_out("R4 following beat cycle 1", 32'h0, 1'b0, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check_out("R4 following beat cycle 2", 32'h0, 1'b1, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check_out("R5 idle after error", 32'h0, 1'b1, 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule